// File: doc/BRIEF.md
# Tower-Field Byte Substitution Unit

This block is the 8-bit nonlinear substitution of a 128-bit block cipher of the SM4 family. It maps each input byte through an affine step, then a multiplicative inversion in GF(2^8), then a second affine step with the same matrix and constant. The substitution is not stored as a table. It is computed arithmetically.

The inversion works in the three-level tower GF(((2^2)^2)^2). The byte is moved into the tower by an isomorphism. That map is folded together with the first affine step into a single constant matrix and offset. Its inverse is folded into the second affine step in the same way. The tower inverse splits a byte into two GF(16) halves and forms their norm. It inverts that norm in GF(16), which itself splits into GF(4) halves, and then scales the conjugate. Every subfield addition is a bitwise XOR.

A parameter selects whether the result is presented combinationally or through one output register.

Top module: `sbox_composite`

## Requirements
- R1: For every input x, `byte_o` equals A·inv(A·x ⊕ C) ⊕ C. The field is GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1, and C = 0xD3. A·v is defined bit by bit: output bit 7−r is the XOR-parity of v ANDed with 8'b11100101 rotated right by r, for r = 0..7.
- R2: The inverse of zero is taken as zero. The input byte whose first affine step gives 0x00 therefore produces exactly 0xD3.
- R3: Inside the tower, the inverter output multiplied by its nonzero input gives the unit element.
- R4: The GF(16) norm inverter returns a value whose product with a nonzero norm is the unit of GF(16).
- R5: With `REG_OUT` = 1, `byte_o` shows the substitution of the byte that was present at the previous rising clock edge.
- R6: With `REG_OUT` = 0, `byte_o` follows `byte_i` in the same cycle, without any clock edge.
- R7: With `REG_OUT` = 1, a low `rst_ni` clears `byte_o` to 0x00 at once, and it stays 0x00 while reset is held.
- R8: The mapping is a permutation: the 256 inputs give 256 distinct outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| byte_i | input | 8 | Byte to substitute |
| byte_o | output | 8 | Substituted byte |

## Verification
Two events can land on the same edge. One is a new byte being captured by the output register while the previous result is still on `byte_o`. The other is a reset that arrives while a byte is in flight. The bench runs registered and combinational copies side by side on one input stream, which changes every cycle. It checks that the registered copy is exactly one byte behind a reference computed by brute-force inverse search, while the combinational copy matches the current byte. It then pulls reset low in mid-stream with a byte pending. That byte must be dropped, and the output must read 0x00 until new data is captured.

// File: rtl/sbox_gf_pkg.sv
package sbox_gf_pkg;

  localparam int GF4_W   = 2;
  localparam int GF16_W  = 2 * GF4_W;
  localparam int GF256_W = 2 * GF16_W;

  typedef logic [GF256_W-1:0][GF256_W-1:0] mat8_t;

  // GF(4) = GF(2)[w]/(w^2+w+1), element {b1,b0} = b1*w + b0
  function automatic logic [GF4_W-1:0] gf4_mul(logic [GF4_W-1:0] a, logic [GF4_W-1:0] b);
    logic [GF4_W-1:0] r;
    r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
    r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
    return r;
  endfunction

  function automatic logic [GF4_W-1:0] gf4_sq(logic [GF4_W-1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // multiply by w, the middle-level constant (lambda)
  function automatic logic [GF4_W-1:0] gf4_mulw(logic [GF4_W-1:0] a);
    return {a[1] ^ a[0], a[1]};
  endfunction

  // GF(16) = GF(4)[z]/(z^2+z+w), element {h,l} = h*z + l
  function automatic logic [GF16_W-1:0] gf16_mul(logic [GF16_W-1:0] a, logic [GF16_W-1:0] b);
    logic [GF4_W-1:0] hh;
    hh = gf4_mul(a[3:2], b[3:2]);
    return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
            gf4_mulw(hh) ^ gf4_mul(a[1:0], b[1:0])};
  endfunction

  function automatic logic [GF16_W-1:0] gf16_sq(logic [GF16_W-1:0] a);
    logic [GF4_W-1:0] hs;
    hs = gf4_sq(a[3:2]);
    return {hs, gf4_mulw(hs) ^ gf4_sq(a[1:0])};
  endfunction

  // norm method: inverse = conj(a) / (lambda*h^2 + h*l + l^2); GF(4) inverse is squaring
  function automatic logic [GF16_W-1:0] gf16_inv(logic [GF16_W-1:0] a);
    logic [GF4_W-1:0] n, ni;
    n  = gf4_mulw(gf4_sq(a[3:2])) ^ gf4_mul(a[3:2], a[1:0]) ^ gf4_sq(a[1:0]);
    ni = gf4_sq(n);
    return {gf4_mul(a[3:2], ni), gf4_mul(a[3:2] ^ a[1:0], ni)};
  endfunction

  // top-level constant nu = w*z, trace one, so y^2+y+nu is irreducible over GF(16)
  localparam logic [GF16_W-1:0] TOP_NU = 4'b1000;

  // square fused with the nu multiply
  function automatic logic [GF16_W-1:0] gf16_sq_nu(logic [GF16_W-1:0] a);
    return gf16_mul(TOP_NU, gf16_sq(a));
  endfunction

  // GF(256) tower = GF(16)[y]/(y^2+y+nu)
  function automatic logic [GF256_W-1:0] gf256_mul(logic [GF256_W-1:0] a, logic [GF256_W-1:0] b);
    logic [GF16_W-1:0] hh;
    hh = gf16_mul(a[7:4], b[7:4]);
    return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
            gf16_mul(TOP_NU, hh) ^ gf16_mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [GF256_W-1:0] mat_apply(mat8_t m, logic [GF256_W-1:0] x);
    logic [GF256_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < GF256_W; i++) if (x[i]) acc ^= m[i];
    return acc;
  endfunction

  // output bit 7-r = parity(x & rotr(row, r))
  function automatic logic [GF256_W-1:0] affine_mul(logic [GF256_W-1:0] row, logic [GF256_W-1:0] x);
    logic [2*GF256_W-1:0] dbl;
    logic [GF256_W-1:0] res;
    dbl = {row, row};
    res = '0;
    for (int r = 0; r < GF256_W; r++) begin
      logic [2*GF256_W-1:0] sh;
      sh = dbl >> r;
      res[3'(GF256_W-1-r)] = ^(sh[GF256_W-1:0] & x);
    end
    return res;
  endfunction

  // smallest tower element that is a root of the binary field polynomial
  function automatic logic [GF256_W-1:0] tower_root(logic [GF256_W:0] poly);
    logic [GF256_W-1:0] found;
    logic hit;
    found = '0;
    hit   = 1'b0;
    for (int c = 1; c < 256; c++) begin
      logic [GF256_W-1:0] cand, pw, acc;
      cand = 8'(c);
      pw   = 8'h01;
      acc  = '0;
      for (int k = 0; k <= GF256_W; k++) begin
        if (poly[k]) acc ^= pw;
        pw = gf256_mul(pw, cand);
      end
      if (!hit && acc == '0) begin
        found = cand;
        hit   = 1'b1;
      end
    end
    return found;
  endfunction

  // columns of the isomorphism: image of x^i is root^i
  function automatic mat8_t iso_cols(logic [GF256_W:0] poly);
    mat8_t m;
    logic [GF256_W-1:0] beta, pw;
    beta = tower_root(poly);
    pw   = 8'h01;
    for (int i = 0; i < GF256_W; i++) begin
      m[i] = pw;
      pw   = gf256_mul(pw, beta);
    end
    return m;
  endfunction

  // isomorphism after the first affine step
  function automatic mat8_t pre_cols(logic [GF256_W-1:0] row, logic [GF256_W:0] poly);
    mat8_t t, m;
    t = iso_cols(poly);
    for (int i = 0; i < GF256_W; i++) m[i] = mat_apply(t, affine_mul(row, 8'(1 << i)));
    return m;
  endfunction

  // inverse isomorphism followed by the second affine step
  function automatic mat8_t post_cols(logic [GF256_W-1:0] row, logic [GF256_W:0] poly);
    mat8_t t, m;
    t = iso_cols(poly);
    m = '0;
    for (int j = 0; j < GF256_W; j++) begin
      for (int x = 0; x < 256; x++) begin
        if (mat_apply(t, 8'(x)) == 8'(1 << j)) m[j] = affine_mul(row, 8'(x));
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/sbox_in_map.sv
module sbox_in_map
  import sbox_gf_pkg::*;
#(
  parameter logic [GF256_W-1:0] AFFINE_ROW   = 8'hE5,
  parameter logic [GF256_W-1:0] AFFINE_CONST = 8'hD3,
  parameter logic [GF256_W:0]   FIELD_POLY   = 9'h1F5
) (
  input  logic [GF256_W-1:0] byte_i,
  output logic [GF256_W-1:0] tower_o
);
  localparam mat8_t              PRE_M = pre_cols(AFFINE_ROW, FIELD_POLY);
  localparam logic [GF256_W-1:0] PRE_K = mat_apply(iso_cols(FIELD_POLY), AFFINE_CONST);

  assign tower_o = mat_apply(PRE_M, byte_i) ^ PRE_K;
endmodule

// File: rtl/sbox_tower_inv.sv
module sbox_tower_inv
  import sbox_gf_pkg::*;
(
  input  logic [GF256_W-1:0] a_i,
  output logic [GF256_W-1:0] inv_o,
  output logic [GF16_W-1:0]  norm_o,
  output logic [GF16_W-1:0]  norm_inv_o
);
  logic [GF16_W-1:0] hi, lo, hl;

  assign hi = a_i[7:4];
  assign lo = a_i[3:0];
  assign hl = hi ^ lo;

  assign norm_o     = gf16_sq_nu(hi) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);
  assign norm_inv_o = gf16_inv(norm_o);
  assign inv_o      = {gf16_mul(hi, norm_inv_o), gf16_mul(hl, norm_inv_o)};
endmodule

// File: rtl/sbox_out_map.sv
module sbox_out_map
  import sbox_gf_pkg::*;
#(
  parameter logic [GF256_W-1:0] AFFINE_ROW   = 8'hE5,
  parameter logic [GF256_W-1:0] AFFINE_CONST = 8'hD3,
  parameter logic [GF256_W:0]   FIELD_POLY   = 9'h1F5
) (
  input  logic [GF256_W-1:0] tower_i,
  output logic [GF256_W-1:0] byte_o
);
  localparam mat8_t POST_M = post_cols(AFFINE_ROW, FIELD_POLY);

  assign byte_o = mat_apply(POST_M, tower_i) ^ AFFINE_CONST;
endmodule

// File: rtl/sbox_composite.sv
module sbox_composite #(
  parameter bit         REG_OUT      = 1'b1,
  parameter logic [7:0] AFFINE_ROW   = 8'hE5,
  parameter logic [7:0] AFFINE_CONST = 8'hD3,
  parameter logic [8:0] FIELD_POLY   = 9'h1F5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  import sbox_gf_pkg::*;

  // named internal events for the checker
  logic [GF256_W-1:0] in_tower;
  logic [GF256_W-1:0] inv_tower;
  logic [GF16_W-1:0]  norm;
  logic [GF16_W-1:0]  norm_inv;
  logic [GF256_W-1:0] s_comb;

  sbox_in_map #(
    .AFFINE_ROW(AFFINE_ROW), .AFFINE_CONST(AFFINE_CONST), .FIELD_POLY(FIELD_POLY)
  ) u_in (
    .byte_i (byte_i),
    .tower_o(in_tower)
  );

  sbox_tower_inv u_inv (
    .a_i       (in_tower),
    .inv_o     (inv_tower),
    .norm_o    (norm),
    .norm_inv_o(norm_inv)
  );

  sbox_out_map #(
    .AFFINE_ROW(AFFINE_ROW), .AFFINE_CONST(AFFINE_CONST), .FIELD_POLY(FIELD_POLY)
  ) u_out (
    .tower_i(inv_tower),
    .byte_o (s_comb)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [GF256_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= s_comb;
      end
      assign byte_o = q;
    end else begin : g_comb
      assign byte_o = s_comb;
    end
  endgenerate
endmodule

module sbox_composite_chk
  import sbox_gf_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] in_tower,
  input logic [7:0] inv_tower,
  input logic [3:0] norm,
  input logic [3:0] norm_inv,
  input logic [7:0] s_comb,
  input logic [7:0] byte_o
);
  a_r2_zero_maps_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tower == 8'h00) |-> (inv_tower == 8'h00));

  a_r3_tower_product_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tower != 8'h00) |-> (gf256_mul(in_tower, inv_tower) == 8'h01));

  a_r4_norm_product_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm != 4'h0) |-> (gf16_mul(norm, norm_inv) == 4'h1));

  generate
    if (REG_OUT) begin : g_reg_chk
      a_r5_one_cycle_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (byte_o == $past(s_comb)));
      a_r7_reset_clears: assert property (@(posedge clk_i)
        !rst_ni |=> (byte_o == 8'h00));
    end else begin : g_comb_chk
      a_r6_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_o == s_comb);
    end
  endgenerate
endmodule

bind sbox_composite sbox_composite_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .in_tower (in_tower),
  .inv_tower(inv_tower),
  .norm     (norm),
  .norm_inv (norm_inv),
  .s_comb   (s_comb),
  .byte_o   (byte_o)
);

// File: tb/test_sbox_composite.sv
module test_sbox_composite;
  localparam int HALF = 4;  // 125 MHz
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [7:0] q_reg, q_comb;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit [255:0] seen;
  int expq[$];

  always #HALF clk = ~clk;

  sbox_composite #(.REG_OUT(1'b1)) i_sbox_composite (
    .clk_i(clk), .rst_ni(rst_ni), .byte_i(byte_i), .byte_o(q_reg));

  sbox_composite #(.REG_OUT(1'b0)) i_sbox_composite_comb (
    .clk_i(clk), .rst_ni(rst_ni), .byte_i(byte_i), .byte_o(q_comb));

  // ---------- behavioural reference ----------
  function automatic int fmul(int a, int b);
    int p = 0;
    for (int k = 0; k < 8; k++) begin
      if ((b >> k) & 1) p ^= a;
      a = a << 1;
      if (a & 256) a ^= 'h1F5;
    end
    return p;
  endfunction

  function automatic int finv(int a);
    int r = 0;
    for (int c = 1; c < 256; c++) if (fmul(a, c) == 1) r = c;
    return r;
  endfunction

  function automatic int lin(int v);
    int o = 0;
    for (int bitpos = 0; bitpos < 8; bitpos++) begin
      int r = 7 - bitpos;
      int rot = (('hE5 >> r) | ('hE5 << (8 - r))) & 255;
      int par = 0;
      for (int k = 0; k < 8; k++) par ^= ((rot & v) >> k) & 1;
      o |= par << bitpos;
    end
    return o;
  endfunction

  function automatic int sref(int x);
    return lin(finv(lin(x) ^ 'hD3)) ^ 'hD3;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one cycle: judge both copies at the negative edge, then drive the next byte
  task automatic step(int v);
    @(negedge clk);
    check("R1/R6 combinational", int'(q_comb), sref(int'(byte_i)));
    if (expq.size() > 0) check("R5 registered", int'(q_reg), expq.pop_front());
    byte_i = 8'(v);
    expq.push_back(sref(v));
  endtask

  initial begin
    #(2 * HALF * WATCHDOG_CYCLES);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int x0 = 0;
    int distinct = 0;
    logic [7:0] lf;

    seen = '0;
    repeat (3) @(negedge clk);
    check("R7 reset value", int'(q_reg), 0);
    rst_ni = 1'b1;

    // exhaustive ascending pass: R1, R3, R4 via every input
    for (int v = 0; v < 256; v++) step(v);
    // descending pass also collects the outputs for R8
    for (int v = 255; v >= 0; v--) begin
      step(v);
      #1;
      check("R1 R3 R4 exhaustive", int'(q_comb), sref(v));
      seen[q_comb] = 1'b1;
    end
    for (int v = 0; v < 256; v++) if (seen[v]) distinct++;
    n_vec++;
    if (distinct != 256) begin
      n_bad++;
      $display("FAIL R8 distinct outputs actual=%0d expected=256", distinct);
    end

    // R2: input whose first affine step yields zero
    for (int v = 0; v < 256; v++) if ((lin(v) ^ 'hD3) == 0) x0 = v;
    step(x0);
    #1;
    check("R2 zero inverse", int'(q_comb), 'hD3);

    // pseudo-random back-to-back stream
    lf = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      step(int'(lf));
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end

    // reset while a byte is pending in the register
    step('h3C);
    #1;
    rst_ni = 1'b0;
    #1;
    check("R7 async clear", int'(q_reg), 0);
    expq.delete();
    @(negedge clk);
    check("R7 held in reset", int'(q_reg), 0);
    check("R6 comb during reset", int'(q_comb), sref('h3C));
    rst_ni = 1'b1;
    for (int v = 17; v < 40; v++) step(v * 7);
    step(0);
    step(0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule